// File: doc/BRIEF.md
# SPI Bit-Clock Rate Generator

This block derives the serial bit clock for a SPI engine from a 200 MHz reference clock by integer division. A 4-bit speed code picks one of several fixed divide ratios. One code hands the choice to a free 6-bit divisor field instead. A separate enable bit arms the fastest (divide-by-2, 100 MHz) setting. The block outputs a serial clock waveform with near-50% duty and a one-cycle tick that marks the end of each bit period. The shift engine uses the tick to advance its shifter.

The engine drives a single run input. While run is low the generator is idle. In that state it keeps its outputs quiet and copies the decoded divisor from the speed inputs on every reference cycle. When run goes high the divisor is frozen and the divider counter starts from zero, so every transaction begins with a full high phase. A controller therefore reprograms the rate between transactions, and any change made during a transaction has no effect until the next one.

The control is a two-state machine. IDLE is the reset state: the outputs are low and the divisor tracks the inputs. RUN means the counter cycles through the frozen divisor. The START transition goes from IDLE to RUN when run is sampled high. The STOP transition goes from RUN back to IDLE when run is sampled low.

Top module: `spi_bitclk_gen`

## Requirements
- R1: After reset the generator is in IDLE, with sclk_o and tick_o both low.
- R2: Speed codes 0, 1, 2 and 3 give bit periods of 3, 6, 9 and 12 reference cycles.
- R3: Speed code 4 gives a period of 2 cycles when fast_en_i is 1, and a period of 3 cycles when fast_en_i is 0.
- R4: Speed code 5 gives a period of 250 cycles.
- R5: Speed code 7 uses aux_div_i as the period, so 0x04, 0x32 and 0x3F give 4, 50 and 63 cycles.
- R6: A period of 250 cycles is used in three cases: speed code 7 with aux_div_i equal to 0 or 1, and speed code 6, and any code from 8 to 15. The active divisor always lies between 2 and 250.
- R7: Within each period, sclk_o is high for the first ceil(N/2) cycles and low for the remaining floor(N/2) cycles, where N is the period.
- R8: tick_o is high for exactly one cycle, the last cycle of each period, and that cycle is in the low phase.
- R9: The divisor is captured only while idle. Changes to speed_code_i, fast_en_i or aux_div_i during RUN do not alter the running period, and they take effect at the next transaction.
- R10: The first cycle after run_i is sampled high starts a new period: the counter is at 0 and sclk_o is high.
- R11: Once run_i is sampled low, the generator returns to IDLE, and from then on sclk_o and tick_o stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 200 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Engine run request; low means idle |
| speed_code_i | input | 4 | Speed select code |
| fast_en_i | input | 1 | Arms the divide-by-2 setting for code 4 |
| aux_div_i | input | 6 | Free divisor used by code 7 |
| sclk_o | output | 1 | Serial bit clock waveform |
| tick_o | output | 1 | One-cycle pulse at the end of each bit period |

## Verification
The bench runs a transaction for every fixed code and measures the high-phase length and the period up to the first tick. Running each code separates the divide ratios from one another. Odd and even divisors such as 3, 9, 12 and 63 separate the ceil/floor duty split from a plain half. Code 4 is run with and without the enable bit, and the free field is run with legal values, with the clamped values 0 and 1, and with the small legal value 3. Together these tell the clamp apart from a pass-through. A speed change made in the middle of a transaction shows whether the divisor is frozen during RUN, and a later transaction shows that the change takes hold afterwards.

// File: rtl/spi_rate_pkg.sv
package spi_rate_pkg;
    localparam int CODE_W   = 4;
    localparam int AUX_W    = 6;
    localparam int DIV_W    = 8;
    localparam int DIV_SLOW = 250;
    localparam int DIV_FAST = 2;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } gen_state_t;
endpackage

// File: rtl/spi_rate_decode.sv
module spi_rate_decode
    import spi_rate_pkg::*;
#(
    parameter int P_CODE_W = CODE_W,
    parameter int P_AUX_W  = AUX_W,
    parameter int P_DIV_W  = DIV_W
) (
    input  logic [P_CODE_W-1:0] code_i,
    input  logic                fast_en_i,
    input  logic [P_AUX_W-1:0]  aux_i,
    output logic [P_DIV_W-1:0]  div_o
);
    localparam logic [P_DIV_W-1:0] SLOW = P_DIV_W'(DIV_SLOW);

    always_comb begin
        case (code_i)
            P_CODE_W'(0): div_o = P_DIV_W'(3);
            P_CODE_W'(1): div_o = P_DIV_W'(6);
            P_CODE_W'(2): div_o = P_DIV_W'(9);
            P_CODE_W'(3): div_o = P_DIV_W'(12);
            P_CODE_W'(4): div_o = fast_en_i ? P_DIV_W'(DIV_FAST) : P_DIV_W'(3);
            P_CODE_W'(5): div_o = SLOW;
            P_CODE_W'(7): div_o = (aux_i < P_AUX_W'(2)) ? SLOW : P_DIV_W'(aux_i);
            default:      div_o = SLOW;
        endcase
    end
endmodule

// File: rtl/spi_rate_counter.sv
module spi_rate_counter
    import spi_rate_pkg::*;
#(
    parameter int P_DIV_W = DIV_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    input  logic               en_i,
    input  logic [P_DIV_W-1:0] div_i,
    output logic [P_DIV_W-1:0] cnt_o,
    output logic               wrap_o
);
    assign wrap_o = (cnt_o == div_i - P_DIV_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_o <= '0;
        else if (clear_i) cnt_o <= '0;
        else if (en_i)    cnt_o <= wrap_o ? '0 : cnt_o + P_DIV_W'(1);
    end
endmodule

// File: rtl/spi_bitclk_gen.sv
module spi_bitclk_gen
    import spi_rate_pkg::*;
#(
    parameter int P_CODE_W = CODE_W,
    parameter int P_AUX_W  = AUX_W,
    parameter int P_DIV_W  = DIV_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_i,
    input  logic [P_CODE_W-1:0] speed_code_i,
    input  logic                fast_en_i,
    input  logic [P_AUX_W-1:0]  aux_div_i,
    output logic                sclk_o,
    output logic                tick_o
);
    gen_state_t         state_q, state_d;
    logic [P_DIV_W-1:0] dec_div, div_q, cnt_q;
    logic               wrap;
    logic [P_DIV_W:0]   hi_len;

    spi_rate_decode #(.P_CODE_W(P_CODE_W), .P_AUX_W(P_AUX_W), .P_DIV_W(P_DIV_W)) u_dec (
        .code_i   (speed_code_i),
        .fast_en_i(fast_en_i),
        .aux_i    (aux_div_i),
        .div_o    (dec_div)
    );

    spi_rate_counter #(.P_DIV_W(P_DIV_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(state_q == ST_IDLE),
        .en_i   (state_q == ST_RUN),
        .div_i  (div_q),
        .cnt_o  (cnt_q),
        .wrap_o (wrap)
    );

    // START: IDLE -> RUN on run_i; STOP: RUN -> IDLE on !run_i
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (run_i)  state_d = ST_RUN;
            ST_RUN:  if (!run_i) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Divisor follows the inputs only while idle (R9)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 div_q <= P_DIV_W'(DIV_SLOW);
        else if (state_q == ST_IDLE) div_q <= dec_div;
    end

    assign hi_len = ({1'b0, div_q} + (P_DIV_W+1)'(1)) >> 1;

    always_comb begin
        sclk_o = 1'b0;
        tick_o = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RUN: begin
                sclk_o = ({1'b0, cnt_q} < hi_len);
                tick_o = wrap;
            end
        endcase
    end
endmodule

// File: rtl/spi_bitclk_gen_chk.sv
module spi_bitclk_gen_chk
    import spi_rate_pkg::*;
#(
    parameter int P_DIV_W = DIV_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               run_i,
    input logic               sclk_o,
    input logic               tick_o,
    input gen_state_t         state_q,
    input logic [P_DIV_W-1:0] cnt_q,
    input logic [P_DIV_W-1:0] div_q
);
    logic in_run;
    assign in_run = (state_q == ST_RUN);

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_run |-> (!sclk_o && !tick_o));

    a_r9_div_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && $past(in_run)) |-> $stable(div_q));

    a_r6_div_range: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q >= P_DIV_W'(2)) && (div_q <= P_DIV_W'(DIV_SLOW)));

    a_r10_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_run) |-> (cnt_q == '0 && sclk_o));

    a_r8_tick_low: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> !sclk_o);

    a_r8_tick_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && run_i) |=> (cnt_q == '0));

    a_r7_rise_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && $past(in_run) && $past(tick_o)) |-> sclk_o);
endmodule

bind spi_bitclk_gen spi_bitclk_gen_chk #(.P_DIV_W(P_DIV_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run_i),
    .sclk_o (sclk_o),
    .tick_o (tick_o),
    .state_q(state_q),
    .cnt_q  (cnt_q),
    .div_q  (div_q)
);

// File: tb/tb_spi_bitclk_gen.sv
module tb_spi_bitclk_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0;
    logic [3:0] code = 4'd0;
    logic       fast = 1'b0;
    logic [5:0] aux = 6'd0;
    logic       sclk, tick;
    int         n_run = 0, n_fail = 0, cyc = 0;

    always #4 clk = ~clk;

    spi_bitclk_gen dut (
        .clk(clk), .rst_n(rst_n), .run_i(run), .speed_code_i(code),
        .fast_en_i(fast), .aux_div_i(aux), .sclk_o(sclk), .tick_o(tick)
    );

    typedef struct packed {
        logic [3:0] code;
        logic       fast;
        logic [5:0] aux;
        logic [7:0] div;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{4'd0,  1'b0, 6'd0,  8'd3},   // R2
        '{4'd1,  1'b0, 6'd0,  8'd6},   // R2
        '{4'd2,  1'b0, 6'd0,  8'd9},   // R2
        '{4'd3,  1'b0, 6'd0,  8'd12},  // R2
        '{4'd4,  1'b1, 6'd0,  8'd2},   // R3
        '{4'd4,  1'b0, 6'd0,  8'd3},   // R3
        '{4'd5,  1'b0, 6'd0,  8'd250}, // R4
        '{4'd7,  1'b0, 6'h04, 8'd4},   // R5
        '{4'd7,  1'b0, 6'h32, 8'd50},  // R5
        '{4'd7,  1'b0, 6'h3F, 8'd63},  // R5
        '{4'd7,  1'b0, 6'd3,  8'd3},   // R5
        '{4'd7,  1'b0, 6'd0,  8'd250}, // R6
        '{4'd7,  1'b0, 6'd1,  8'd250}, // R6
        '{4'd6,  1'b0, 6'd9,  8'd250}, // R6
        '{4'd15, 1'b1, 6'd9,  8'd250}  // R6
    };

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Raise run, then measure first-cycle sclk, high length and cycles to tick.
    task automatic start_measure(output int first, output int hi, output int per);
        run = 1'b1;
        hi = 0; per = 0; first = 0;
        for (int i = 1; i <= 300; i++) begin
            @(negedge clk);
            if (i == 1) first = int'(sclk);
            if (sclk && hi == i - 1) hi++;
            if (tick) begin per = i; break; end
        end
    endtask

    task automatic stop_run();
        run = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 150000", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int first, hi, per, gap;
        @(negedge clk);
        @(negedge clk);
        check("R1 sclk in reset", int'(sclk), 0);
        check("R1 tick in reset", int'(tick), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 sclk after reset", int'(sclk), 0);
        check("R1 tick after reset", int'(tick), 0);

        for (int v = 0; v < NV; v++) begin
            code = VECS[v].code; fast = VECS[v].fast; aux = VECS[v].aux;
            @(negedge clk);
            start_measure(first, hi, per);
            check($sformatf("R10 first cycle high, vec %0d", v), first, 1);
            check($sformatf("R7 high phase, vec %0d", v), hi, (int'(VECS[v].div) + 1) / 2);
            check($sformatf("R2-R6 period (R8 tick), vec %0d", v), per, int'(VECS[v].div));
            stop_run();
        end

        // R8: tick lasts one cycle; R7: sclk high again after it
        code = 4'd1; fast = 1'b0;
        @(negedge clk);
        start_measure(first, hi, per);
        @(negedge clk);
        check("R8 tick single cycle", int'(tick), 0);
        check("R7 rise after tick", int'(sclk), 1);
        stop_run();

        // R9: change mid-transaction is ignored
        code = 4'd0;
        @(negedge clk);
        start_measure(first, hi, per);
        code = 4'd5;
        gap = 0;
        for (int i = 1; i <= 300; i++) begin
            @(negedge clk);
            if (tick) begin gap = i; break; end
        end
        check("R9 period held during run", gap, 3);
        // R11: quiet after stop
        run = 1'b0;
        @(negedge clk);
        check("R11 sclk after stop", int'(sclk), 0);
        check("R11 tick after stop", int'(tick), 0);
        repeat (5) @(negedge clk);
        check("R11 sclk still idle", int'(sclk), 0);
        // R9: new setting used at next transaction
        start_measure(first, hi, per);
        check("R9 new period after idle", per, 250);
        stop_run();

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule